// File: doc/BRIEF.md
# Two-Cache Snooping Lock Coherence Model

This block models two processor-side caches that share one cache block holding a lock word. Each cache runs its own four-state MESI controller. The caches reach a common backing memory over a single snooped bus. A fixed-priority arbiter grants at most one bus transaction per cycle. Each processor port takes load, store and atomic-swap requests, one at a time. It answers with a one-cycle done strobe and the returned data.

The model exists to get lock acquisition right when both caches hold the line Shared and both try to take it in the same cycle. A swap that starts from Shared first reads the value it holds locally. It then asks the bus for an invalidate. If the peer's invalidate is granted first, the waiting cache drops to Invalid. Its swap then completes at once with the "held" value instead of the stale free value it had read. Software treats a swap result of 1 as a failed acquire and releases the lock with a plain store of 0.

A port accepts a request only in a cycle when the peer's transaction is not on the bus. A request presented in such a cycle waits in place until the next cycle.

Top module: `mesi_swap_pair`

## Requirements
- R1: After reset both caches report Invalid, the bus shows idle, no done strobe is raised, and the memory word is 0.
- R2: A load that hits returns the held value without a bus transaction. A load on an Invalid line issues a bus read. If the peer is Invalid, the line is installed Exclusive and the returned value comes from memory.
- R3: A store to a line in Exclusive or Modified leaves it Modified and puts no transaction on the bus.
- R4: A load miss while the peer holds the line takes the peer's copy if it is Modified (memory is updated in the same transaction) or memory otherwise; both caches end Shared.
- R5: A store to a line in Shared or Invalid issues a read-exclusive. The writer ends Modified and the peer ends Invalid.
- R6: The arbiter grants at most one cache per cycle, only a requesting one, and on a tie grants the cache selected by parameter PRIO_CACHE.
- R7: When both caches hold the line Shared and both start a swap in the same cycle, the arbitration winner returns the old value (0) and ends Modified. The loser ends Invalid and returns LOCKED_VAL (1). The two results are never both 0.
- R8: A store of 0 releases the lock, so the next swap on that word returns 0.
- R9: At no cycle does more than one cache hold Exclusive or Modified, and whenever one does, the other is Invalid.
- R10: Encodings are as follows. Bus ops: 00 idle, 01 read, 10 read-exclusive/invalidate, 11 write-back (never issued, because the owner's flush is merged into the read). Line states: 00 Invalid, 01 Shared, 10 Exclusive, 11 Modified. Request codes: 00 load, 01 store, 10 swap.
- R11: A swap on a line in Exclusive or Modified completes locally. It returns the old value, writes the new one, and ends Modified with no bus transaction.
- R12: A swap on an Invalid line issues a read-exclusive. It returns the value supplied by the Modified peer or by memory, and ends Modified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 2 | Request strobe, bit c for cache c |
| req_op_i | input | 4 | Request code, bits [2c+1:2c] for cache c |
| req_wdata_i | input | 2*DATA_W | Store/swap data, slice c for cache c |
| done_o | output | 2 | One-cycle completion strobe per cache |
| rdata_o | output | 2*DATA_W | Returned data per cache, valid with done |
| state_o | output | 4 | Line state per cache, bits [2c+1:2c] |
| bus_op_o | output | 2 | Op of the transaction granted this cycle |
| bus_grant_o | output | 2 | One-hot bus grant |

## Verification
Most corrupted line states show up on state_o in the same cycle, as two owners or an owner beside a valid copy. The rest show up on the returned data at the next done strobe. A missed snoop during the race leaves a swap waiting or returning 0 on both ports, and the race check catches this within the two cycles a race takes. A wrong supplier choice shows up as a stale value on the next load miss. A wrong tie-break shows up as the wrong winner state on the next race. The same races are run with each cache given priority.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_E = 2'b10,
    ST_M = 2'b11
  } mesi_e;

  typedef enum logic [1:0] {
    BUS_IDLE = 2'b00,
    BUS_RD   = 2'b01,
    BUS_RDX  = 2'b10,
    BUS_WB   = 2'b11
  } bus_op_e;

  typedef enum logic [1:0] {
    REQ_LD   = 2'b00,
    REQ_ST   = 2'b01,
    REQ_SWAP = 2'b10,
    REQ_RSVD = 2'b11
  } req_e;
endpackage

// File: rtl/mesi_arbiter.sv
module mesi_arbiter #(
  parameter int N_REQ = 2,
  parameter int PRIO  = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_REQ-1:0] req_i,
  output logic [N_REQ-1:0] grant_o
);
  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1;

  always_comb begin
    logic found;
    found   = 1'b0;
    grant_o = '0;
    for (int i = 0; i < N_REQ; i++) begin
      int unsigned idx;
      idx = (PRIO + i) % N_REQ;
      if (!found && req_i[idx[IDX_W-1:0]]) begin
        grant_o[idx[IDX_W-1:0]] = 1'b1;
        found = 1'b1;
      end
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o)); // R6
  AST_GRANT_HAS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o != '0) |-> ((grant_o & req_i) == grant_o)); // R6
  AST_TIE_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&req_i) |-> grant_o[PRIO]); // R6
endmodule

// File: rtl/mesi_mem.sv
module mesi_mem #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      word_q <= '0;
    else if (wr_en_i) word_q <= wr_data_i;
  end

  assign rdata_o = word_q;
endmodule

// File: rtl/mesi_cache.sv
module mesi_cache
  import mesi_pkg::*;
#(
  parameter int          DATA_W     = 8,
  parameter int unsigned LOCKED_VAL = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  req_e              req_op_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              grant_i,
  input  bus_op_e           snoop_op_i,
  input  mesi_e             peer_state_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic              bus_req_o,
  output bus_op_e           bus_op_o,
  output mesi_e             state_o,
  output logic [DATA_W-1:0] line_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [DATA_W-1:0] LOCKED = DATA_W'(LOCKED_VAL);

  typedef enum logic {F_IDLE, F_WAIT} fsm_e;

  fsm_e              fsm_q, fsm_d;
  mesi_e             st_q, st_d;
  bus_op_e           bop_q, bop_d;
  req_e              op_q, op_d;
  logic [DATA_W-1:0] line_q, line_d, wdata_q, wdata_d, rdata_q, rdata_d;
  logic              race_q, race_d, done_q, done_d;
  logic              snooping, owned;

  assign snooping = (snoop_op_i != BUS_IDLE);
  assign owned    = (st_q == ST_E) || (st_q == ST_M);

  always_comb begin
    fsm_d   = fsm_q;
    st_d    = st_q;
    bop_d   = bop_q;
    op_d    = op_q;
    line_d  = line_q;
    wdata_d = wdata_q;
    rdata_d = rdata_q;
    race_d  = race_q;
    done_d  = 1'b0;

    // peer transaction on the bus
    if (snoop_op_i == BUS_RD && st_q != ST_I) st_d = ST_S;
    if (snoop_op_i == BUS_RDX)                st_d = ST_I;

    unique case (fsm_q)
      F_IDLE: begin
        if (req_valid_i && !snooping) begin
          op_d    = req_op_i;
          wdata_d = req_wdata_i;
          case (req_op_i)
            REQ_ST: begin
              if (owned) begin
                line_d  = req_wdata_i;
                st_d    = ST_M;
                rdata_d = req_wdata_i;
                done_d  = 1'b1;
              end else begin
                fsm_d  = F_WAIT;
                bop_d  = BUS_RDX;
                race_d = 1'b0;
              end
            end
            REQ_SWAP: begin
              if (owned) begin
                rdata_d = line_q;
                line_d  = req_wdata_i;
                st_d    = ST_M;
                done_d  = 1'b1;
              end else begin
                // read phase done from the Shared copy; invalidate still pending
                fsm_d  = F_WAIT;
                bop_d  = BUS_RDX;
                race_d = (st_q == ST_S);
              end
            end
            default: begin
              if (st_q != ST_I) begin
                rdata_d = line_q;
                done_d  = 1'b1;
              end else begin
                fsm_d  = F_WAIT;
                bop_d  = BUS_RD;
                race_d = 1'b0;
              end
            end
          endcase
        end
      end
      F_WAIT: begin
        if (grant_i) begin
          fsm_d  = F_IDLE;
          done_d = 1'b1;
          race_d = 1'b0;
          if (bop_q == BUS_RD) begin
            line_d  = bus_rdata_i;
            rdata_d = bus_rdata_i;
            st_d    = (peer_state_i != ST_I) ? ST_S : ST_E;
          end else begin
            rdata_d = (op_q == REQ_ST) ? wdata_q : bus_rdata_i;
            line_d  = wdata_q;
            st_d    = ST_M;
          end
        end else if (race_q && snoop_op_i == BUS_RDX) begin
          // lost the upgrade race: the earlier read is stale
          fsm_d   = F_IDLE;
          done_d  = 1'b1;
          rdata_d = LOCKED;
          race_d  = 1'b0;
        end
      end
      default: fsm_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsm_q   <= F_IDLE;
      st_q    <= ST_I;
      bop_q   <= BUS_IDLE;
      op_q    <= REQ_LD;
      line_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      race_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      fsm_q   <= fsm_d;
      st_q    <= st_d;
      bop_q   <= bop_d;
      op_q    <= op_d;
      line_q  <= line_d;
      wdata_q <= wdata_d;
      rdata_q <= rdata_d;
      race_q  <= race_d;
      done_q  <= done_d;
    end
  end

  assign bus_req_o = (fsm_q == F_WAIT);
  assign bus_op_o  = (fsm_q == F_WAIT) ? bop_q : BUS_IDLE;
  assign state_o   = st_q;
  assign line_o    = line_q;
  assign done_o    = done_q;
  assign rdata_o   = rdata_q;

  AST_SILENT_UPGRADE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_E) |=> (st_q != ST_M || !$past(bus_req_o))); // R3
  AST_LOSER_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsm_q == F_WAIT && race_q && snoop_op_i == BUS_RDX && !grant_i)
      |=> (done_o && rdata_o == LOCKED && st_q == ST_I)); // R7
  AST_RDX_WINS_M: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_i && bus_op_o == BUS_RDX) |=> (st_q == ST_M && done_o)); // R5
endmodule

// File: rtl/mesi_swap_pair.sv
module mesi_swap_pair
  import mesi_pkg::*;
#(
  parameter int          DATA_W     = 8,
  parameter int          PRIO_CACHE = 0,
  parameter int unsigned LOCKED_VAL = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          req_valid_i,
  input  logic [3:0]          req_op_i,
  input  logic [2*DATA_W-1:0] req_wdata_i,
  output logic [1:0]          done_o,
  output logic [2*DATA_W-1:0] rdata_o,
  output logic [3:0]          state_o,
  output logic [1:0]          bus_op_o,
  output logic [1:0]          bus_grant_o
);
  localparam int N_CACHE = 2;

  mesi_e             st_w   [N_CACHE];
  bus_op_e           bop_w  [N_CACHE];
  logic [DATA_W-1:0] line_w [N_CACHE];
  logic [N_CACHE-1:0] breq_w, grant_w;
  logic [DATA_W-1:0] mem_rdata, mem_wdata;
  logic              mem_we;

  mesi_arbiter #(.N_REQ(N_CACHE), .PRIO(PRIO_CACHE)) u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (breq_w),
    .grant_o(grant_w)
  );

  mesi_mem #(.DATA_W(DATA_W)) u_mem (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (mem_we),
    .wr_data_i(mem_wdata),
    .rdata_o  (mem_rdata)
  );

  for (genvar c = 0; c < N_CACHE; c++) begin : g_cache
    localparam int PEER = N_CACHE - 1 - c;
    bus_op_e           snoop;
    logic [DATA_W-1:0] brdata;

    assign snoop  = grant_w[PEER] ? bop_w[PEER] : BUS_IDLE;
    assign brdata = (st_w[PEER] == ST_M) ? line_w[PEER] : mem_rdata;

    mesi_cache #(.DATA_W(DATA_W), .LOCKED_VAL(LOCKED_VAL)) u_cache (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .req_valid_i (req_valid_i[c]),
      .req_op_i    (req_e'(req_op_i[2*c +: 2])),
      .req_wdata_i (req_wdata_i[DATA_W*c +: DATA_W]),
      .grant_i     (grant_w[c]),
      .snoop_op_i  (snoop),
      .peer_state_i(st_w[PEER]),
      .bus_rdata_i (brdata),
      .bus_req_o   (breq_w[c]),
      .bus_op_o    (bop_w[c]),
      .state_o     (st_w[c]),
      .line_o      (line_w[c]),
      .done_o      (done_o[c]),
      .rdata_o     (rdata_o[DATA_W*c +: DATA_W])
    );

    assign state_o[2*c +: 2] = st_w[c];
  end

  // granted op on the bus; a Modified peer flushes into memory in the same cycle
  always_comb begin
    bus_op_o  = BUS_IDLE;
    mem_we    = 1'b0;
    mem_wdata = mem_rdata;
    for (int c = 0; c < N_CACHE; c++) begin
      if (grant_w[c]) begin
        bus_op_o = bop_w[c];
        if (st_w[N_CACHE-1-c] == ST_M) begin
          mem_we    = 1'b1;
          mem_wdata = line_w[N_CACHE-1-c];
        end
      end
    end
  end

  assign bus_grant_o = grant_w;

  AST_SINGLE_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_w[0] == ST_E || st_w[0] == ST_M || st_w[1] == ST_E || st_w[1] == ST_M)
      |-> (st_w[0] == ST_I || st_w[1] == ST_I)); // R9
  AST_NO_WB_ISSUED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_op_o != BUS_WB); // R10
endmodule

// File: tb/mesi_swap_pair_test.sv
module mesi_swap_pair_test;
  localparam int DW    = 8;
  localparam int NROWS = 18;

  typedef struct packed {
    logic          en0;
    logic [1:0]    op0;
    logic [DW-1:0] wd0;
    logic          en1;
    logic [1:0]    op1;
    logic [DW-1:0] wd1;
    logic          race;
    logic [DW-1:0] r0;
    logic [DW-1:0] r1;
    logic [1:0]    s0;
    logic [1:0]    s1;
    logic [1:0]    bop;
  } vec_t;

  // ops: 0 load, 1 store, 2 swap; states: 0 I, 1 S, 2 E, 3 M; bus: 1 read, 2 read-excl
  localparam vec_t VEC [NROWS] = '{
    '{1'b1, 2'd0, 8'd0, 1'b0, 2'd0, 8'd0, 1'b0, 8'd0, 8'd0, 2'd2, 2'd0, 2'd1},
    '{1'b1, 2'd1, 8'd5, 1'b0, 2'd0, 8'd0, 1'b0, 8'd5, 8'd0, 2'd3, 2'd0, 2'd0},
    '{1'b0, 2'd0, 8'd0, 1'b1, 2'd0, 8'd0, 1'b0, 8'd0, 8'd5, 2'd1, 2'd1, 2'd1},
    '{1'b0, 2'd0, 8'd0, 1'b1, 2'd1, 8'd0, 1'b0, 8'd0, 8'd0, 2'd0, 2'd3, 2'd2},
    '{1'b1, 2'd0, 8'd0, 1'b0, 2'd0, 8'd0, 1'b0, 8'd0, 8'd0, 2'd1, 2'd1, 2'd1},
    '{1'b1, 2'd2, 8'd1, 1'b1, 2'd2, 8'd1, 1'b1, 8'd0, 8'd0, 2'd0, 2'd0, 2'd2},
    '{1'b1, 2'd0, 8'd0, 1'b1, 2'd0, 8'd0, 1'b0, 8'd1, 8'd1, 2'd1, 2'd1, 2'd1},
    '{1'b1, 2'd1, 8'd0, 1'b0, 2'd0, 8'd0, 1'b0, 8'd0, 8'd0, 2'd3, 2'd0, 2'd2},
    '{1'b0, 2'd0, 8'd0, 1'b1, 2'd2, 8'd1, 1'b0, 8'd0, 8'd0, 2'd0, 2'd3, 2'd2},
    '{1'b1, 2'd2, 8'd1, 1'b0, 2'd0, 8'd0, 1'b0, 8'd1, 8'd0, 2'd3, 2'd0, 2'd2},
    '{1'b1, 2'd1, 8'd0, 1'b0, 2'd0, 8'd0, 1'b0, 8'd0, 8'd0, 2'd3, 2'd0, 2'd0},
    '{1'b1, 2'd2, 8'd1, 1'b0, 2'd0, 8'd0, 1'b0, 8'd0, 8'd0, 2'd3, 2'd0, 2'd0},
    '{1'b1, 2'd1, 8'd0, 1'b0, 2'd0, 8'd0, 1'b0, 8'd0, 8'd0, 2'd3, 2'd0, 2'd0},
    '{1'b0, 2'd0, 8'd0, 1'b1, 2'd0, 8'd0, 1'b0, 8'd0, 8'd0, 2'd1, 2'd1, 2'd1},
    '{1'b1, 2'd2, 8'd1, 1'b1, 2'd2, 8'd1, 1'b1, 8'd0, 8'd0, 2'd0, 2'd0, 2'd2},
    '{1'b1, 2'd0, 8'd0, 1'b1, 2'd0, 8'd0, 1'b0, 8'd1, 8'd1, 2'd1, 2'd1, 2'd1},
    '{1'b0, 2'd0, 8'd0, 1'b1, 2'd1, 8'd0, 1'b0, 8'd0, 8'd0, 2'd0, 2'd3, 2'd2},
    '{1'b0, 2'd0, 8'd0, 1'b1, 2'd0, 8'd0, 1'b0, 8'd0, 8'd0, 2'd0, 2'd3, 2'd0}
  };

  string row_tag [NROWS] = '{"R2", "R3", "R4", "R5", "R4", "R7", "R4", "R5", "R12",
                             "R12", "R8", "R11", "R8", "R4", "R7", "R4", "R5", "R2"};

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [1:0]    req_valid = '0;
  logic [3:0]    req_op = '0;
  logic [2*DW-1:0] req_wdata = '0;
  logic [1:0]    done_x  [2];
  logic [2*DW-1:0] rdata_x [2];
  logic [3:0]    state_x [2];
  logic [1:0]    bop_x   [2];
  logic [1:0]    grant_x [2];

  int checks = 0;
  int fails  = 0;

  always #10 clk_i = ~clk_i;

  mesi_swap_pair #(.DATA_W(DW), .PRIO_CACHE(0)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_wdata_i(req_wdata), .done_o(done_x[0]), .rdata_o(rdata_x[0]),
    .state_o(state_x[0]), .bus_op_o(bop_x[0]), .bus_grant_o(grant_x[0])
  );

  mesi_swap_pair #(.DATA_W(DW), .PRIO_CACHE(1)) uut_rev (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_wdata_i(req_wdata), .done_o(done_x[1]), .rdata_o(rdata_x[1]),
    .state_o(state_x[1]), .bus_op_o(bop_x[1]), .bus_grant_o(grant_x[1])
  );

  task automatic chk(input string tag, input string what, input int k,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s inst%0d: actual %0h expected %0h", tag, what, k, act, exp);
    end
  endtask

  // R9 and R6 checked on every cycle
  always @(negedge clk_i) begin
    if (rst_ni) begin
      for (int k = 0; k < 2; k++) begin
        logic [1:0] s0, s1;
        s0 = state_x[k][1:0];
        s1 = state_x[k][3:2];
        chk("R9", "single owner", k, {31'd0, (s0[1] && s1 != 2'd0) || (s1[1] && s0 != 2'd0)}, 32'd0);
        chk("R6", "grant onehot", k, {31'd0, &grant_x[k]}, 32'd0);
      end
    end
  end

  task automatic run_row(input int idx);
    vec_t          v;
    logic          got_d [2][2];
    logic [DW-1:0] got_r [2][2];
    logic [1:0]    first_op [2];
    logic          all_done;
    v = VEC[idx];
    for (int k = 0; k < 2; k++) begin
      first_op[k] = 2'd0;
      for (int p = 0; p < 2; p++) begin
        got_d[k][p] = 1'b0;
        got_r[k][p] = '0;
      end
    end
    req_valid = {v.en1, v.en0};
    req_op    = {v.op1, v.op0};
    req_wdata = {v.wd1, v.wd0};
    all_done  = 1'b0;
    for (int cyc = 0; cyc < 20 && !all_done; cyc++) begin
      @(negedge clk_i);
      if (cyc == 0) req_valid = '0;
      all_done = 1'b1;
      for (int k = 0; k < 2; k++) begin
        if (first_op[k] == 2'd0) first_op[k] = bop_x[k];
        for (int p = 0; p < 2; p++) begin
          if (done_x[k][p] && !got_d[k][p]) begin
            got_d[k][p] = 1'b1;
            got_r[k][p] = rdata_x[k][DW*p +: DW];
          end
        end
        if (v.en0 && !got_d[k][0]) all_done = 1'b0;
        if (v.en1 && !got_d[k][1]) all_done = 1'b0;
      end
    end
    for (int k = 0; k < 2; k++) begin
      logic [DW-1:0] er [2];
      logic [1:0]    es [2];
      er[0] = v.r0; er[1] = v.r1;
      es[0] = v.s0; es[1] = v.s1;
      if (v.race) begin
        // uut gives cache 0 the tie, uut_rev cache 1
        er[k] = 8'd0;  er[1-k] = 8'd1;
        es[k] = 2'd3;  es[1-k] = 2'd0;
        chk("R7", "both swaps 0", k, {31'd0, (got_r[k][0] == 0) && (got_r[k][1] == 0)}, 32'd0);
        chk("R6", "tie winner M", k, {30'd0, state_x[k][2*k +: 2]}, 32'd3);
      end
      for (int p = 0; p < 2; p++) begin
        if ((p == 0 && v.en0) || (p == 1 && v.en1)) begin
          chk(row_tag[idx], "done", k, {31'd0, got_d[k][p]}, 32'd1);
          chk(row_tag[idx], "rdata", k, {24'd0, got_r[k][p]}, {24'd0, er[p]});
        end
        chk(row_tag[idx], "state", k, {30'd0, state_x[k][2*p +: 2]}, {30'd0, es[p]});
      end
      chk("R10", "bus op", k, {30'd0, first_op[k]}, {30'd0, v.bop});
    end
    @(negedge clk_i);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state, held in reset
    for (int k = 0; k < 2; k++) begin
      chk("R1", "reset state", k, {28'd0, state_x[k]}, 32'd0);
      chk("R1", "reset bus", k, {30'd0, bop_x[k]}, 32'd0);
      chk("R1", "reset done", k, {30'd0, done_x[k]}, 32'd0);
    end
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    for (int k = 0; k < 2; k++) begin
      chk("R1", "idle bus after reset", k, {30'd0, bop_x[k]}, 32'd0);
      chk("R1", "idle state after reset", k, {28'd0, state_x[k]}, 32'd0);
    end
    for (int i = 0; i < NROWS; i++) run_row(i);

    // directed: reset again, then R12 swap from Invalid reads memory 0 (R1 memory reset)
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int k = 0; k < 2; k++)
      chk("R1", "state after re-reset", k, {28'd0, state_x[k]}, 32'd0);
    req_valid = 2'b10; req_op = 4'b1000; req_wdata = {8'd1, 8'd0};
    @(negedge clk_i);
    req_valid = '0;
    @(negedge clk_i);
    for (int k = 0; k < 2; k++) begin
      chk("R12", "swap from I done", k, {31'd0, done_x[k][1]}, 32'd1);
      chk("R12", "swap from I old value", k, {24'd0, rdata_x[k][DW +: DW]}, 32'd0);
      chk("R12", "swap from I state", k, {30'd0, state_x[k][3:2]}, 32'd3);
    end
    @(negedge clk_i);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule